// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block turns two divided clock enables, one for the CPU domain and one for the PCI domain, into a set of gated clock outputs. All of them are generated in a single fast reference clock domain. A power-management mode input arms three active-low controls. The first parks the CPU outputs. The second parks the gated PCI outputs. The third puts the whole block into a low-power state. In that state every output is low, the oscillator enable drops and the serial programming pins are released to high impedance.

Each output is a register that changes only on a divided enable pulse. A stop or sleep request therefore takes effect at the next rising opportunity. A clock that is already high always finishes its high phase, so no output ever shows a shortened pulse. A small configuration register bank sits alongside the clock gating. It keeps its contents through power down and ignores writes while the block is asleep.

A status vector reports which output groups are currently held low.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `pm_mode_n` is high, the three stop and power-down inputs have no effect. Every output toggles with a CPU period of two `cpu_tick` pulses and a PCI period of two `pci_tick` pulses, and `osc_en` stays 1.
- R2: While in power-management mode with `cpu_stop_n` low, every `cpu_clk` bit stays low. `aux_clk`, `pci_clk` and `pci_free` keep toggling.
- R3: After `cpu_stop_n` is released, `cpu_clk` withholds at least RESTART further rising opportunities (default 3 CPU periods) before its first rising edge.
- R4: While in power-management mode with `pci_stop_n` low, every `pci_clk` bit stays low. `pci_free`, `cpu_clk` and `aux_clk` keep toggling.
- R5: When `pd_n` goes low in power-management mode, each output finishes any high phase and then stays low. `osc_en` falls within PD_LIMIT cycles of the synchronized request.
- R6: While asleep (`osc_en` low), `ser_hiz` is 1. The configuration registers keep their contents and `cfg_we` has no effect on them.
- R7: After `pd_n` returns high, `osc_en` rises again and `ser_hiz` drops. All outputs then stay low for SETTLE reference cycles before the first rising edge.
- R8: Outputs change only on a cycle that carries their domain's tick. Every high phase lasts exactly one tick interval: 2 reference cycles for `cpu_clk` and 4 for `pci_clk` at the bench rates.
- R9: `stopped` bit 0 covers the CPU group, bit 1 the gated PCI group, bit 2 `pci_free` and bit 3 `aux_clk`. A bit is set when its group's rising edge was withheld and cleared when the group rises.
- R10: After reset, all clock outputs are 0, `osc_en` is 1, `ser_hiz` is 0, `stopped` is 0 and every configuration register reads 0.
- R11: In the awake state, a cycle with `cfg_we` high writes `cfg_wdata` into the register indexed by `cfg_addr`. `cfg_rdata` shows the register at `cfg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | fast reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cpu_tick | input | 1 | CPU-domain divided enable, one pulse per half period |
| pci_tick | input | 1 | PCI-domain divided enable, one pulse per half period |
| pm_mode_n | input | 1 | low selects power-management mode |
| cpu_stop_n | input | 1 | active-low CPU clock stop, sampled on clk |
| pci_stop_n | input | 1 | active-low gated PCI clock stop, sampled on clk |
| pd_n | input | 1 | asynchronous active-low power-down request |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | AW | configuration register index |
| cfg_wdata | input | CW | configuration write data |
| cfg_rdata | output | CW | configuration read data |
| cpu_clk | output | NCPU | gated CPU clocks |
| pci_clk | output | NPCI | gated PCI clocks |
| pci_free | output | 1 | PCI clock stopped only by power down |
| aux_clk | output | 1 | memory-side clock at CPU rate, stopped only by power down |
| osc_en | output | 1 | oscillator enable, low while asleep |
| ser_hiz | output | 1 | high-impedance request for the serial programming pins |
| stopped | output | 4 | per-group held-low status |

## Verification
The assertions take for granted that each tick arrives as a single-cycle pulse and that ticks are spaced far enough apart that a PCI half period fits inside PD_LIMIT. The settle and entry-bound checks depend on that spacing. The bench generates ticks from a fixed divider, with a CPU tick every second cycle and a PCI tick every fourth cycle, so both conditions always hold. The bench changes `pm_mode_n` only while no stop is pending whose release it later measures, and it holds each control level for many CPU periods. As a result, every counted window starts from a settled gating state.

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int NCPU     = 2,
  parameter int NPCI     = 3,
  parameter int NREG     = 4,
  parameter int CW       = 8,
  parameter int RESTART  = 3,
  parameter int SETTLE   = 16,
  parameter int PD_LIMIT = 64,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_tick,
  input  logic            pci_tick,
  input  logic            pm_mode_n,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic            pd_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  output logic [CW-1:0]   cfg_rdata,
  output logic [NCPU-1:0] cpu_clk,
  output logic [NPCI-1:0] pci_clk,
  output logic            pci_free,
  output logic            aux_clk,
  output logic            osc_en,
  output logic            ser_hiz,
  output logic [3:0]      stopped
);
  localparam int RW = $clog2(RESTART + 1);
  localparam int SW = $clog2(SETTLE + 1);
  localparam int PW = $clog2(PD_LIMIT + 2);
  localparam logic [RW-1:0] CNT_FULL = RW'(RESTART);

  logic          cstop_s, pstop_s;
  logic [1:0]    pd_sync;
  logic          cpu_ph, pci_ph;
  logic          cpu_q, pci_q, pcif_q, aux_q;
  logic [RW-1:0] cnt;
  logic [3:0]    stat;
  logic          asleep;
  logic [SW-1:0] settle;
  logic [NREG*CW-1:0] bank;

  wire pm       = ~pm_mode_n;
  wire cstop    = pm & ~cstop_s;
  wire pstop    = pm & ~pstop_s;
  wire pd_req   = pm & ~pd_sync[1];
  wire block    = pd_req | asleep | (settle != '0);
  wire cpu_rise = cpu_tick & ~cpu_ph;
  wire cpu_fall = cpu_tick & cpu_ph;
  wire pci_rise = pci_tick & ~pci_ph;
  wire pci_fall = pci_tick & pci_ph;
  wire cpu_ok   = ~block & ~cstop & (cnt == CNT_FULL);
  wire any_high = cpu_q | pci_q | pcif_q | aux_q;

  // control sampling and power-down synchronizer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cstop_s <= 1'b1;
      pstop_s <= 1'b1;
      pd_sync <= 2'b11;
    end else begin
      cstop_s <= cpu_stop_n;
      pstop_s <= pci_stop_n;
      pd_sync <= {pd_sync[0], pd_n};
    end

  // CPU domain: rise only at a low-to-high opportunity, so high phases are never cut
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_ph  <= 1'b0;
      cpu_q   <= 1'b0;
      aux_q   <= 1'b0;
      cnt     <= CNT_FULL;
      stat[0] <= 1'b0;
      stat[3] <= 1'b0;
    end else begin
      if (cpu_tick) cpu_ph <= ~cpu_ph;
      if (cstop) cnt <= '0;
      else if (cpu_rise && cnt != CNT_FULL) cnt <= cnt + 1'b1;
      if (cpu_rise) begin
        cpu_q   <= cpu_ok;
        aux_q   <= ~block;
        stat[0] <= ~cpu_ok;
        stat[3] <= block;
      end else if (cpu_fall) begin
        cpu_q <= 1'b0;
        aux_q <= 1'b0;
      end
    end

  // PCI domain
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pci_ph  <= 1'b0;
      pci_q   <= 1'b0;
      pcif_q  <= 1'b0;
      stat[1] <= 1'b0;
      stat[2] <= 1'b0;
    end else begin
      if (pci_tick) pci_ph <= ~pci_ph;
      if (pci_rise) begin
        pci_q   <= ~block & ~pstop;
        pcif_q  <= ~block;
        stat[1] <= block | pstop;
        stat[2] <= block;
      end else if (pci_fall) begin
        pci_q  <= 1'b0;
        pcif_q <= 1'b0;
      end
    end

  // sleep entry once every output is low; settle window on exit
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      asleep <= 1'b0;
      settle <= '0;
    end else if (!asleep) begin
      if (pd_req && !any_high) asleep <= 1'b1;
      if (settle != '0) settle <= settle - 1'b1;
    end else if (!pd_req) begin
      asleep <= 1'b0;
      settle <= SW'(SETTLE);
    end

  // configuration bank, retained through sleep
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bank[i*CW +: CW] <= '0;
      else if (cfg_we && !asleep && cfg_addr == AW'(i)) bank[i*CW +: CW] <= cfg_wdata;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (cfg_addr == AW'(i)) cfg_rdata = bank[i*CW +: CW];
  end

  assign cpu_clk  = {NCPU{cpu_q}};
  assign pci_clk  = {NPCI{pci_q}};
  assign pci_free = pcif_q;
  assign aux_clk  = aux_q;
  assign osc_en   = ~asleep;
  assign ser_hiz  = asleep;
  assign stopped  = stat;

  // entry-latency watch for the bounded power-down entry
  logic [PW-1:0] pd_wait;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pd_wait <= '0;
    else if (pd_req && !asleep) begin
      if (pd_wait != '1) pd_wait <= pd_wait + 1'b1;
    end else pd_wait <= '0;

  assert_mode_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode_n && !asleep && settle == '0 && cnt == CNT_FULL && cpu_rise) |=> cpu_q);
  assert_cpu_park_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cstop && cpu_rise) |=> (cpu_clk == '0));
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_q) |-> $past(cnt == CNT_FULL && !cstop));
  assert_pci_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstop && pci_rise) |=> (pci_clk == '0));
  assert_free_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!block && pci_rise) |=> pci_free);
  assert_sleep_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !any_high);
  assert_entry_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_wait <= PW'(PD_LIMIT));
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && cfg_we) |=> $stable(bank));
  assert_settle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle != '0) |-> !any_high);
  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tick |=> $stable(cpu_q));
  assert_pci_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_tick |=> $stable(pci_q));
  assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_q) |-> !stopped[0]);
endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;
  localparam int K_CPU = 0, K_PCI = 1, K_PCIF = 2, K_AUX = 3, K_OSC = 4, K_HIZ = 5,
                 K_STAT = 6, K_RD = 7, N_CPU = 8, N_PCI = 9, N_PCIF = 10, N_AUX = 11, K_CLR = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_tick = 1'b0, pci_tick = 1'b0;
  logic pm_mode_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [1:0] cpu_clk;
  logic [2:0] pci_clk;
  logic pci_free, aux_clk, osc_en, ser_hiz;
  logic [3:0] stopped;

  clkstop_ctrl uut (.clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .pci_tick(pci_tick),
    .pm_mode_n(pm_mode_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pd_n(pd_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free(pci_free), .aux_clk(aux_clk),
    .osc_en(osc_en), .ser_hiz(ser_hiz), .stopped(stopped));

  always #2.5 clk = ~clk;

  typedef struct { string req; int kind; int exp; bit ge; } item_t;
  item_t q[$];
  int errors = 0, checks = 0;
  int n_cpu = 0, n_pci = 0, n_pcif = 0, n_aux = 0;
  int w_cpu = 0, w_pci = 0;
  logic p_cpu = 0, p_pci = 0, p_pcif = 0, p_aux = 0;

  // ticks: CPU every 2 cycles (period 4), PCI every 4 cycles (period 8)
  int tcyc = 0;
  initial forever begin
    @(posedge clk); #1;
    tcyc++;
    cpu_tick = (tcyc % 2 == 0);
    pci_tick = (tcyc % 4 == 0);
  end

  function automatic int value(int kind);
    case (kind)
      K_CPU:  return int'(cpu_clk);
      K_PCI:  return int'(pci_clk);
      K_PCIF: return int'(pci_free);
      K_AUX:  return int'(aux_clk);
      K_OSC:  return int'(osc_en);
      K_HIZ:  return int'(ser_hiz);
      K_STAT: return int'(stopped);
      K_RD:   return int'(cfg_rdata);
      N_CPU:  return n_cpu;
      N_PCI:  return n_pci;
      N_PCIF: return n_pcif;
      N_AUX:  return n_aux;
      default: return -1;
    endcase
  endfunction

  // monitor: count edges, check pulse widths (R8), then drain the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_clk[0] && !p_cpu) n_cpu++;
      if (pci_clk[0] && !p_pci) n_pci++;
      if (pci_free && !p_pcif) n_pcif++;
      if (aux_clk && !p_aux) n_aux++;
      if (cpu_clk[0]) w_cpu++;
      else if (p_cpu) begin
        checks++;
        if (w_cpu != 2) begin errors++; $display("FAIL R8 cpu high width actual=%0d expected=2", w_cpu); end
        w_cpu = 0;
      end
      if (pci_clk[0]) w_pci++;
      else if (p_pci) begin
        checks++;
        if (w_pci != 4) begin errors++; $display("FAIL R8 pci high width actual=%0d expected=4", w_pci); end
        w_pci = 0;
      end
    end
    p_cpu = cpu_clk[0]; p_pci = pci_clk[0]; p_pcif = pci_free; p_aux = aux_clk;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.kind == K_CLR) begin
        n_cpu = 0; n_pci = 0; n_pcif = 0; n_aux = 0;
      end else begin
        int v;
        bit ok;
        v = value(it.kind);
        ok = it.ge ? (v >= it.exp) : (v == it.exp);
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%0d expected%s%0d", it.req, it.kind, v, it.ge ? ">=" : "=", it.exp);
        end
      end
    end
  end

  task automatic push(string req, int kind, int exp, bit ge = 0);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp; it.ge = ge;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic counts(string req, int c, int p, int pf, int a);
    push(req, N_CPU, c); push(req, N_PCI, p); push(req, N_PCIF, pf); push(req, N_AUX, a);
  endtask

  task automatic wr(int addr, int data);
    cfg_addr = 2'(addr); cfg_wdata = 8'(data); cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    step(3);
    // R10: reset state
    push("R10", K_CPU, 0); push("R10", K_PCI, 0); push("R10", K_OSC, 1);
    push("R10", K_HIZ, 0); push("R10", K_STAT, 0); push("R10", K_RD, 0);
    step(1);
    rst_n = 1'b1;
    step(10);

    // R11: configuration writes and reads
    wr(1, 'h3C); wr(2, 'hA5);
    cfg_addr = 2'd1; push("R11", K_RD, 'h3C);
    step(1);
    cfg_addr = 2'd2; push("R11", K_RD, 'hA5);
    step(1);

    // normal run, mode high
    push("R1", K_CLR, 0); step(80);
    counts("R1", 20, 10, 10, 20);
    step(1);

    // R1: mode high, every control asserted, nothing changes
    cpu_stop_n = 0; pci_stop_n = 0; pd_n = 0;
    step(20);
    push("R1", K_CLR, 0); step(80);
    counts("R1", 20, 10, 10, 20);
    push("R1", K_OSC, 1); push("R1", K_STAT, 0);
    step(1);

    // R2: CPU stop in power-management mode
    pd_n = 1; pci_stop_n = 1;
    step(5);
    pm_mode_n = 0;
    step(20);
    push("R2", K_CLR, 0); step(80);
    counts("R2", 0, 10, 10, 20);
    push("R9", K_STAT, 4'b0001);
    step(1);

    // R3: restart latency
    cpu_stop_n = 1;
    push("R3", K_CLR, 0);
    step(12);
    push("R3", N_CPU, 0);
    step(20);
    push("R3", N_CPU, 1, 1);
    step(10);
    push("R9", K_STAT, 0);
    step(1);

    // R4: PCI stop
    pci_stop_n = 0;
    step(20);
    push("R4", K_CLR, 0); step(80);
    counts("R4", 20, 0, 10, 20);
    push("R9", K_STAT, 4'b0010);
    step(1);
    pci_stop_n = 1;
    step(20);
    push("R4", K_CLR, 0); step(80);
    counts("R4", 20, 10, 10, 20);
    step(1);

    // R5/R6: power down
    pd_n = 0;
    step(16);
    push("R5", K_OSC, 0); push("R6", K_HIZ, 1); push("R9", K_STAT, 4'b1111);
    push("R5", K_CPU, 0); push("R5", K_PCI, 0);
    step(1);
    push("R5", K_CLR, 0); step(40);
    counts("R5", 0, 0, 0, 0);
    step(1);
    wr(1, 'h5A);
    cfg_addr = 2'd1; push("R6", K_RD, 'h3C);
    step(1);

    // R7: wake and settle
    pd_n = 1;
    push("R7", K_CLR, 0);
    step(6);
    push("R7", K_OSC, 1); push("R7", K_HIZ, 0);
    step(10);
    push("R7", N_CPU, 0); push("R7", N_AUX, 0); push("R7", N_PCIF, 0);
    step(24);
    push("R7", N_CPU, 1, 1); push("R7", N_PCIF, 1, 1); push("R7", N_AUX, 1, 1);
    push("R6", K_RD, 'h3C);
    step(2);

    summary();
    $finish;
  end
endmodule